// File: doc/BRIEF.md
# I2C Two-Register Configuration Target

This block is an I2C target that holds two 8-bit configuration registers, A and B, and drives them into core logic as live outputs. It runs on a fast system clock. SCL and SDA are oversampled through synchronizers. The block pulls SDA low through an open-drain enable output. Its 7-bit bus address is fixed once, when reset is released, from an address-select input.

A master can do two things. It can write a register address followed by one or two data bytes; when register A is the target, a second byte rolls over into register B. It can also read the register selected by the current pointer, with no address phase. Written bytes are first held in shadow copies. They are copied to the live outputs only when a Stop ends the transaction, so the core never sees a half-finished update.

Top module: `i2c_cfg_target`

## Requirements
- R1: The first byte after a Start holds the 7-bit address, MSB first, and then a direction bit (0 = write, 1 = read). When the address matches, the block pulls SDA low during the ninth SCL pulse as an ACK. The address is 1000110 (0x46) with the select input low and 1000111 (0x47) with it high.
- R2: The select input is sampled when reset is released. Any later change on it has no effect on the address until the next reset.
- R3: On an address mismatch the block never drives SDA, so the ninth bit reads as NACK. It then ignores every byte, and leaves the registers unchanged, until the next Start.
- R4: In a write, the byte after the control byte is a register address. 0x00 selects register A and 0x01 selects register B. Either value is ACKed and becomes the read pointer.
- R5: Any other register address is NACKed. The pointer stays unchanged, and every data byte that follows is NACKed and discarded.
- R6: The first data byte after a valid register address is stored in the selected register and ACKed.
- R7: After a byte has been written to register A, a further byte without a Stop goes to register B and is ACKed. Any byte after a register B write is NACKed and discarded.
- R8: The live outputs change only at a Stop. A repeated Start does not apply pending writes, and a read before the Stop returns the old live value.
- R9: A read returns the live value of the register at the pointer, MSB first, with SDA changed while SCL is low. If the master ACKs, the same register is sent again. If the master NACKs, SDA is released until the next Start.
- R10: After reset, both outputs are 0x00, the pointer selects register A and SDA is released.
- R11: SDA is driven only in a target ACK slot or during a read data bit. It is released in the master's acknowledge slot and at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Address-select input, sampled when reset is released |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_a_o | output | 8 | Live value of register A |
| cfg_b_o | output | 8 | Live value of register B |

## Verification
The bench targets the roll-over limit. A design that rolls a third byte back into register A, or that lets a write aimed at B roll on, shows up as a wrong ACK and as a corrupted output after Stop. A repeated Start placed between a write and a read exposes a design that applies pending data early, because the read returns the new value instead of the old one. Bad register addresses and foreign control addresses are mixed into random traffic, which catches a design that moves the pointer or stores discarded bytes. Toggling the select input after reset catches an address that follows the pin live.

// File: rtl/i2c_cfg_pkg.sv
`timescale 1ns/1ps
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int NREGS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_REG,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } phase_e;
endpackage

// File: rtl/i2c_cfg_sync.sv
`timescale 1ns/1ps
module i2c_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] scl_sh, sda_sh;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
    end
  end

  assign scl_now = scl_sh[LAST-1];
  assign scl_old = scl_sh[LAST];
  assign sda_now = sda_sh[LAST-1];
  assign sda_old = sda_sh[LAST];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  // data edges while the clock is held high
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_cfg_regs.sv
`timescale 1ns/1ps
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_A = '0,
  parameter logic [BYTE_W-1:0] RST_B = '0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic                               wr_sel_i,
  input  logic [BYTE_W-1:0]                  wr_data_i,
  input  logic                               commit_i,
  output logic [NREGS-1:0][BYTE_W-1:0]       live_o
);
  logic [NREGS-1:0][BYTE_W-1:0] shadow_q, live_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] RV = (g == 0) ? RST_A : RST_B;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= RV;
        live_q[g]   <= RV;
      end else begin
        if (wr_en_i && (wr_sel_i == 1'(g))) shadow_q[g] <= wr_data_i;
        if (commit_i) live_q[g] <= shadow_q[g];
      end
    end

    // R8
    live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit_i |=> $stable(live_q[g]));
  end

  assign live_o = live_q;
endmodule

// File: rtl/i2c_cfg_engine.sv
`timescale 1ns/1ps
module i2c_cfg_engine
  import i2c_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_oe_o,
  output logic              ptr_o,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o
);
  localparam logic [BYTE_W-1:0] NREGS_B = BYTE_W'(NREGS);
  localparam logic [3:0] BIT_LAST = 4'(BYTE_W);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W + 1);

  phase_e            phase;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, tx_q;
  logic              oe_q, rw_q, ack_q, mack_q, ptr_q, widx_q, wok_q;
  logic              byte_ack, byte_end, slot_end;

  always_comb begin
    byte_ack = 1'b0;
    case (phase)
      ST_CTRL:  byte_ack = (shreg[BYTE_W-1:1] == dev_addr_i);
      ST_REG:   byte_ack = (shreg < NREGS_B);
      ST_WDATA: byte_ack = wok_q;
      default:  byte_ack = 1'b0;
    endcase
  end

  assign byte_end = scl_fall_i && (bit_cnt == BIT_LAST);
  assign slot_end = scl_fall_i && (bit_cnt == ACK_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= 1'b0;
      widx_q  <= 1'b0;
      wok_q   <= 1'b0;
    end else if (stop_i) begin
      phase   <= ST_IDLE;
      oe_q    <= 1'b0;
      bit_cnt <= '0;
    end else if (start_i) begin
      phase   <= ST_CTRL;
      oe_q    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      case (phase)
        ST_CTRL, ST_REG, ST_WDATA: begin
          if (scl_rise_i && (bit_cnt < BIT_LAST)) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            oe_q    <= byte_ack;
            ack_q   <= byte_ack;
            bit_cnt <= ACK_SLOT;
            if (phase == ST_CTRL) rw_q <= shreg[0];
            if (phase == ST_REG && byte_ack) begin
              ptr_q  <= shreg[0];
              widx_q <= shreg[0];
              wok_q  <= 1'b1;
            end
            if (phase == ST_WDATA && wok_q) begin
              if (widx_q) wok_q <= 1'b0;
              else        widx_q <= 1'b1;
            end
          end else if (slot_end) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            if (!ack_q) begin
              phase <= ST_SKIP;
            end else if (phase == ST_CTRL) begin
              if (rw_q) begin
                phase <= ST_RDATA;
                tx_q  <= rd_byte_i;
                oe_q  <= ~rd_byte_i[BYTE_W-1];
              end else begin
                phase <= ST_REG;
              end
            end else begin
              phase <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) begin
            if (bit_cnt == BIT_LAST) begin
              mack_q  <= ~sda_i;
              bit_cnt <= ACK_SLOT;
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
            end
          end else if (scl_fall_i) begin
            if (bit_cnt == BIT_LAST) begin
              oe_q <= 1'b0;
            end else if (bit_cnt == ACK_SLOT) begin
              bit_cnt <= '0;
              if (mack_q) begin
                tx_q <= rd_byte_i;
                oe_q <= ~rd_byte_i[BYTE_W-1];
              end else begin
                oe_q  <= 1'b0;
                phase <= ST_SKIP;
              end
            end else if (bit_cnt != 4'd0) begin
              oe_q <= ~tx_q[BYTE_W-2];
              tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_en_o   = (phase == ST_WDATA) && byte_end && wok_q && !stop_i && !start_i;
  assign wr_sel_o  = widx_q;
  assign wr_data_o = shreg;
  assign commit_o  = stop_i;

  // R11
  oe_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> (bit_cnt == ACK_SLOT) || (phase == ST_RDATA));
  // R3
  skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_SKIP || phase == ST_IDLE) |-> !oe_q);
  // R9
  mack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_RDATA && bit_cnt == ACK_SLOT) |-> !oe_q);
  // R7
  write_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (bit_cnt == ACK_SLOT) && oe_q);
endmodule

// File: rtl/i2c_cfg_target.sv
`timescale 1ns/1ps
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [5:0]        ADDR_HI     = 6'b100011,
  parameter logic [BYTE_W-1:0] RST_A       = '0,
  parameter logic [BYTE_W-1:0] RST_B       = '0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_sel_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] cfg_a_o,
  output logic [BYTE_W-1:0] cfg_b_o
);
  logic sel_q, lock_q;
  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic ptr, wr_en, wr_sel, commit;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [NREGS-1:0][BYTE_W-1:0] live;

  // address select captured once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      sel_q  <= addr_sel_i;
      lock_q <= 1'b1;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(sel_q));

  i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_cfg_engine u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .dev_addr_i ({ADDR_HI, sel_q}),
    .rd_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_sel_o   (wr_sel),
    .wr_data_o  (wr_data),
    .commit_o   (commit)
  );

  i2c_cfg_regs #(.RST_A(RST_A), .RST_B(RST_B)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .commit_i  (commit),
    .live_o    (live)
  );

  assign rd_byte = live[ptr];
  assign cfg_a_o = live[0];
  assign cfg_b_o = live[1];
endmodule

// File: tb/i2c_cfg_target_test.sv
`timescale 1ns/1ps
module i2c_cfg_target_test;
  localparam int Q = 24;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [7:0] cfg_a, cfg_b;
  wire sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_cfg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_sel_i(sel), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cfg_a_o(cfg_a), .cfg_b_o(cfg_b)
  );

  int n_chk = 0, n_bad = 0;
  logic [6:0] m_addr;
  logic [7:0] ma, mb, sa, sb;
  logic mptr;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] addr_for(input logic s);
    return {6'b100011, s};
  endfunction

  function automatic logic [7:0] model_rd();
    return mptr ? mb : ma;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #Q; #Q; m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = ~sda_bus; #Q; m_scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1'b1; #Q; b[i] = sda_bus; #Q; m_scl = 1'b0; #Q;
    end
    m_sda = ~mack; #Q; m_scl = 1'b1; #Q; #Q; m_scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  task automatic finish_txn(input string tag);
    bus_stop();
    repeat (4) @(negedge clk);
    ma = sa; mb = sb;
    check({tag, " R6 cfg_a after stop"}, cfg_a, ma);
    check({tag, " R7 cfg_b after stop"}, cfg_b, mb);
    check({tag, " R11 sda released"}, sda_oe, 1'b0);
  endtask

  task automatic do_reset(input logic s);
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0; sel = s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_addr = addr_for(s);
    ma = 8'h00; mb = 8'h00; sa = 8'h00; sb = 8'h00; mptr = 1'b0;
    check("R10 cfg_a reset", cfg_a, 8'h00);
    check("R10 cfg_b reset", cfg_b, 8'h00);
    check("R10 sda released", sda_oe, 1'b0);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] ra, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input string tag);
    logic ack, ok, wok, widx;
    logic [7:0] d;
    bus_start();
    send_byte({a, 1'b0}, ack);
    ok = (a == m_addr);
    check({tag, " R1 ctrl ack"}, ack, ok);
    send_byte(ra, ack);
    wok = 1'b0; widx = 1'b0;
    ok = ok && (ra < 8'd2);
    check({tag, " R4 reg ack"}, ack, ok);
    if (ok) begin mptr = ra[0]; widx = ra[0]; wok = 1'b1; end
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(d, ack);
      check({tag, " R7 data ack"}, ack, ok && wok);
      if (ok && wok) begin
        if (widx) begin sb = d; wok = 1'b0; end
        else begin sa = d; widx = 1'b1; end
      end else begin
        ok = 1'b0;
      end
    end
    check({tag, " R8 cfg_a before stop"}, cfg_a, ma);
    check({tag, " R8 cfg_b before stop"}, cfg_b, mb);
    finish_txn(tag);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b1}, ack);
    check({tag, " R1 read ctrl ack"}, ack, a == m_addr);
    if (a == m_addr) begin
      for (int k = 0; k < n; k++) begin
        recv_byte(k < n - 1, b);
        check({tag, " R9 read data"}, b, model_rd());
      end
    end else begin
      recv_byte(1'b0, b);
      check({tag, " R3 foreign read stays released"}, b, 8'hFF);
    end
    finish_txn(tag);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] b;
    int unsigned seed;
    seed = $urandom(32'd4711);

    do_reset(1'b0);
    do_read(m_addr, 1, "R10 ptr reset");
    do_write(m_addr, 8'h00, 1, 8'h5A, 8'h00, 8'h00, "R6 single A");
    do_write(m_addr, 8'h01, 1, 8'hC3, 8'h00, 8'h00, "R6 single B");
    do_write(m_addr, 8'h00, 2, 8'h11, 8'h22, 8'h00, "R7 roll A to B");
    do_write(m_addr, 8'h00, 3, 8'h33, 8'h44, 8'h55, "R7 third byte");
    do_write(m_addr, 8'h01, 2, 8'h66, 8'h77, 8'h00, "R7 no roll past B");
    do_write(m_addr, 8'h02, 1, 8'hEE, 8'h00, 8'h00, "R5 bad reg 02");
    do_write(m_addr, 8'h80, 2, 8'hEE, 8'hDD, 8'h00, "R5 bad reg 80");
    do_read(m_addr, 1, "R5 pointer kept");
    do_write(7'h47, 8'h00, 2, 8'hAB, 8'hCD, 8'h00, "R3 foreign write");
    do_read(7'h47, 1, "R3 foreign read");
    do_write(m_addr, 8'h00, 0, 8'h00, 8'h00, 8'h00, "R4 ptr to A");
    do_read(m_addr, 3, "R9 repeated bytes A");

    // R8: repeated start between write and read keeps old live value
    bus_start();
    send_byte({m_addr, 1'b0}, ack); check("R8 rs ctrl", ack, 1'b1);
    send_byte(8'h01, ack);          check("R8 rs reg", ack, 1'b1);
    mptr = 1'b1;
    send_byte(8'h99, ack);          check("R8 rs data", ack, 1'b1);
    sb = 8'h99;
    check("R8 live b before stop", cfg_b, mb);
    bus_start();
    send_byte({m_addr, 1'b1}, ack); check("R8 rs read ctrl", ack, 1'b1);
    recv_byte(1'b0, b);
    check("R8 read returns old live", b, mb);
    finish_txn("R8 rs stop");

    // R2: select pin moves after reset, address must not
    sel = 1'b1;
    repeat (8) @(negedge clk);
    do_write(7'h47, 8'h00, 1, 8'h12, 8'h00, 8'h00, "R2 late sel ignored 47");
    do_write(7'h46, 8'h00, 1, 8'h34, 8'h00, 8'h00, "R2 late sel ignored 46");

    for (int it = 0; it < 40; it++) begin
      int unsigned op;
      logic [6:0] a;
      logic [7:0] ra;
      op = $urandom % 8;
      a  = (op == 0) ? 7'($urandom) : m_addr;
      ra = (op == 1) ? 8'($urandom) : 8'($urandom % 2);
      if (op >= 6) do_read(a, 1 + int'($urandom % 2), "R9 random read");
      else do_write(a, ra, int'($urandom % 4), 8'($urandom), 8'($urandom), 8'($urandom),
                    "R7 random write");
    end

    do_reset(1'b1);
    do_write(7'h47, 8'h01, 1, 8'hA5, 8'h00, 8'h00, "R1 addr 47 with sel high");
    do_write(7'h46, 8'h00, 1, 8'h5A, 8'h00, 8'h00, "R1 addr 46 rejected");
    do_read(m_addr, 2, "R9 read after sel high");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule